// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Condition Flags

This block is a purely combinational 8-bit arithmetic and logic unit. It takes a destination operand, a source operand and a 3-bit operation code. It returns an 8-bit result, a 16-bit product, and six condition flags. Each flag has its own write enable. The enclosing datapath decides which flags to commit to its status register.

The operations are add, subtract, bitwise AND, increment, decrement, logical shift left and an unsigned 8x8 multiply. A flag whose enable is low is driven as 0. The holder of the status register keeps its old value for that flag.

Top module: `alu8_flags`

## Requirements
- R1: When the N enable (bit 2 of `flag_en`) is high, N (bit 2 of `flags`) equals bit 7 of `result`.
- R2: When the Z enable (bit 1) is high, Z (bit 1) is 1 exactly when `result` is 0x00, for both arithmetic and logic operations.
- R3: When the S enable (bit 4) is high, S (bit 4) equals N XOR V, where V is bit 3.
- R4: ADD (code 0) gives `rd_val + rr_val` modulo 256. C (bit 0) is the carry out of bit 7. H (bit 5) is the carry out of bit 3. V is set when both operands share a sign and the result sign differs from it. All six enables are high.
- R5: SUB (code 1) gives `rd_val - rr_val` modulo 256. C is 1 exactly when `rd_val < rr_val` unsigned. H is the borrow out of the low nibble. V is set when the operand signs differ and the result sign differs from `rd_val`. All six enables are high.
- R6: AND (code 2) gives the bitwise AND and clears V. The enables for S, V, N and Z are high, and those for H and C are low (`flag_en` = 6'h1E).
- R7: INC (code 3) and DEC (code 4) add or subtract 1 modulo 256. V is set only on 0x7F to 0x80 for INC and on 0x80 to 0x7F for DEC. `flag_en` = 6'h1E, so C is never enabled.
- R8: LSL (code 5) shifts `rd_val` left and loads 0 into bit 0. C takes the old bit 7, and V = N XOR C. `flag_en` = 6'h1F.
- R9: MUL (code 6) drives `product` with the unsigned 16-bit product. The low byte (destined for R0) also appears on `result`. The high byte is destined for R1. All enables are low. For every other code, `product` is 0.
- R10: Every flag bit whose enable is low reads 0. Code 7 is reserved: `result`, `product`, `flags` and `flag_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_val | input | 8 | Destination operand (x of x-y) |
| rr_val | input | 8 | Source operand (y of x-y) |
| op_sel | input | 3 | Operation code: 0 ADD, 1 SUB, 2 AND, 3 INC, 4 DEC, 5 LSL, 6 MUL, 7 reserved |
| result | output | 8 | 8-bit result |
| product | output | 16 | Multiply product, 0 unless MUL |
| flags | output | 6 | {H,S,V,N,Z,C}, bit 5 down to bit 0 |
| flag_en | output | 6 | Per-flag update enables, same bit order |

## Verification
The block holds no state, so any fault shows at the ports in the same evaluation as the input that exposes it. There is no latency to wait out. The faults most likely to stay hidden are a borrow polarity inverted on subtraction, a half-carry taken from the wrong nibble boundary, and an enable asserted for a flag the operation must leave alone. The stimulus therefore aims at the points where these flip: 0x7F/0x80 sign crossings, 0x0F/0x10 nibble crossings, zero results and equal operands. Sweeps over every operand value check the carry and the wrap-around against an arithmetic model.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic [7:0]  rd_val,
  input  logic [7:0]  rr_val,
  input  logic [2:0]  op_sel,
  output logic [7:0]  result,
  output logic [15:0] product,
  output logic [5:0]  flags,
  output logic [5:0]  flag_en
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_INC = 3'd3,
                         OP_DEC = 3'd4, OP_LSL = 3'd5, OP_MUL = 3'd6;

  logic [8:0] sum9, dif9;
  logic [4:0] lo_sum, lo_dif;
  logic       hc, vf, cf, nf, zf, sf;

  assign sum9   = {1'b0, rd_val} + {1'b0, rr_val};
  assign dif9   = {1'b0, rd_val} - {1'b0, rr_val};
  assign lo_sum = {1'b0, rd_val[3:0]} + {1'b0, rr_val[3:0]};
  assign lo_dif = {1'b0, rd_val[3:0]} - {1'b0, rr_val[3:0]};

  always_comb begin
    result  = 8'h00;
    product = 16'h0000;
    hc = 1'b0; vf = 1'b0; cf = 1'b0;
    flag_en = 6'h00;
    case (op_sel)
      OP_ADD: begin
        result  = sum9[7:0];
        cf      = sum9[8];
        hc      = lo_sum[4];
        vf      = (rd_val[7] == rr_val[7]) && (sum9[7] != rd_val[7]);
        flag_en = 6'h3F;
      end
      OP_SUB: begin
        result  = dif9[7:0];
        cf      = dif9[8];
        hc      = lo_dif[4];
        vf      = (rd_val[7] != rr_val[7]) && (dif9[7] != rd_val[7]);
        flag_en = 6'h3F;
      end
      OP_AND: begin
        result  = rd_val & rr_val;
        flag_en = 6'h1E;
      end
      OP_INC: begin
        result  = rd_val + 8'd1;
        vf      = (rd_val == 8'h7F);
        flag_en = 6'h1E;
      end
      OP_DEC: begin
        result  = rd_val - 8'd1;
        vf      = (rd_val == 8'h80);
        flag_en = 6'h1E;
      end
      OP_LSL: begin
        result  = {rd_val[6:0], 1'b0};
        cf      = rd_val[7];
        vf      = rd_val[6] ^ rd_val[7];
        flag_en = 6'h1F;
      end
      OP_MUL: begin
        product = {8'h00, rd_val} * {8'h00, rr_val};
        result  = product[7:0];
      end
      default: ;
    endcase
  end

  assign nf    = result[7];
  assign zf    = (result == 8'h00);
  assign sf    = nf ^ vf;
  assign flags = {hc, sf, vf, nf, zf, cf} & flag_en;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic [7:0]  rd_val,
  input logic [7:0]  rr_val,
  input logic [2:0]  op_sel,
  input logic [7:0]  result,
  input logic [15:0] product,
  input logic [5:0]  flags,
  input logic [5:0]  flag_en
);
  always_comb begin
    if (flag_en[2]) a_r1_n_msb: assert (flags[2] == result[7]);
    if (flag_en[1]) a_r2_zero: assert (flags[1] == (result == 8'h00));
    if (flag_en[4]) a_r3_sign: assert (flags[4] == (flags[2] ^ flags[3]));
    if (op_sel == 3'd0) a_r4_add_carry: assert ({flags[0], result} == 9'(rd_val) + 9'(rr_val));
    if (op_sel == 3'd1) a_r5_sub_borrow: assert (flags[0] == (rd_val < rr_val));
    if (op_sel == 3'd2) a_r6_and_en: assert (flag_en == 6'h1E && flags[3] == 1'b0);
    if (op_sel == 3'd3 || op_sel == 3'd4) a_r7_incdec_no_c: assert (flag_en[0] == 1'b0 && flag_en[5] == 1'b0);
    if (op_sel == 3'd5) a_r8_lsl_carry: assert (flags[0] == rd_val[7] && result[0] == 1'b0);
    if (op_sel == 3'd6) a_r9_mul: assert (product == 16'(rd_val) * 16'(rr_val) && result == product[7:0]);
    a_r10_masked: assert ((flags & ~flag_en) == 6'h00);
  end
endmodule

bind alu8_flags alu8_flags_chk u_chk (.*);

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  rd_val, rr_val, result;
  logic [2:0]  op_sel;
  logic [15:0] product;
  logic [5:0]  flags, flag_en;

  alu8_flags dut (.rd_val(rd_val), .rr_val(rr_val), .op_sel(op_sel), .result(result),
                  .product(product), .flags(flags), .flag_en(flag_en));

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // {op, a, b, result, product, flags{H,S,V,N,Z,C}, enables}
  localparam int NV = 19;
  localparam logic [54:0] VECS [NV] = '{
    {3'd0, 8'h0F, 8'h01, 8'h10, 16'h0000, 6'h20, 6'h3F}, // R4 half carry
    {3'd0, 8'h7F, 8'h01, 8'h80, 16'h0000, 6'h2C, 6'h3F}, // R4 overflow
    {3'd0, 8'hFF, 8'h01, 8'h00, 16'h0000, 6'h23, 6'h3F}, // R4 carry, R2
    {3'd0, 8'h80, 8'h80, 8'h00, 16'h0000, 6'h1B, 6'h3F}, // R4 neg overflow, R3
    {3'd1, 8'h05, 8'h07, 8'hFE, 16'h0000, 6'h35, 6'h3F}, // R5 borrow
    {3'd1, 8'h80, 8'h01, 8'h7F, 16'h0000, 6'h38, 6'h3F}, // R5 overflow
    {3'd1, 8'h33, 8'h33, 8'h00, 16'h0000, 6'h02, 6'h3F}, // R5 equal
    {3'd2, 8'hF0, 8'h8F, 8'h80, 16'h0000, 6'h14, 6'h1E}, // R6
    {3'd2, 8'h0F, 8'hF0, 8'h00, 16'h0000, 6'h02, 6'h1E}, // R6 zero
    {3'd3, 8'h7F, 8'h55, 8'h80, 16'h0000, 6'h0C, 6'h1E}, // R7 inc ovf
    {3'd3, 8'hFF, 8'h00, 8'h00, 16'h0000, 6'h02, 6'h1E}, // R7 inc wrap
    {3'd4, 8'h80, 8'hAA, 8'h7F, 16'h0000, 6'h18, 6'h1E}, // R7 dec ovf
    {3'd4, 8'h01, 8'h00, 8'h00, 16'h0000, 6'h02, 6'h1E}, // R7 dec zero
    {3'd5, 8'h81, 8'h00, 8'h02, 16'h0000, 6'h19, 6'h1F}, // R8
    {3'd5, 8'h40, 8'h00, 8'h80, 16'h0000, 6'h0C, 6'h1F}, // R8
    {3'd5, 8'h80, 8'h00, 8'h00, 16'h0000, 6'h1B, 6'h1F}, // R8 zero
    {3'd6, 8'hFF, 8'hFF, 8'h01, 16'hFE01, 6'h00, 6'h00}, // R9
    {3'd6, 8'h10, 8'h20, 8'h00, 16'h0200, 6'h00, 6'h00}, // R9
    {3'd7, 8'h12, 8'h34, 8'h00, 16'h0000, 6'h00, 6'h00}  // R10 reserved
  };

  task automatic apply(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    op_sel = o; rd_val = a; rr_val = b;
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (op %0d a %h b %h)", req, act, exp, op_sel, rd_val, rr_val);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    op_sel = 3'd0; rd_val = 8'h00; rr_val = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(3'd0, 8'h00, 8'h00);
    check("R2 reset idle result", 32'(result), 32'h00);
    check("R2 reset idle flags", 32'(flags), 32'h02);

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      v = VECS[i];
      apply(v[54:52], v[51:44], v[43:36]);
      check("R1-R10 vector result", 32'(result), 32'(v[35:28]));
      check("R9 vector product", 32'(product), 32'(v[27:12]));
      check("R10 vector flags", 32'(flags), 32'(v[11:6]));
      check("R10 vector enables", 32'(flag_en), 32'(v[5:0]));
    end

    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 13) begin
        int s;
        s = a + b;
        apply(3'd0, 8'(a), 8'(b));
        check("R4 sweep sum", 32'({flags[0], result}), 32'(s[8:0]));
        check("R4 sweep H", 32'(flags[5]), 32'(((a % 16) + (b % 16)) > 15));
        apply(3'd1, 8'(a), 8'(b));
        check("R5 sweep diff", 32'(result), 32'((a - b) & 255));
        check("R5 sweep C", 32'(flags[0]), 32'(a < b));
        check("R3 sweep S", 32'(flags[4]), 32'(flags[2] ^ flags[3]));
      end
    end

    for (int a = 0; a < 256; a++) begin
      apply(3'd3, 8'(a), 8'h00);
      check("R7 inc sweep", 32'(result), 32'((a + 1) & 255));
      check("R7 inc V", 32'(flags[3]), 32'(a == 127));
      check("R1 inc N", 32'(flags[2]), 32'(((a + 1) & 255) >= 128));
      apply(3'd6, 8'(a), 8'(255 - a));
      check("R9 mul sweep", 32'(product), 32'(a * (255 - a)));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule